// File: doc/BRIEF.md
# FIFO Occupancy Status Flag Generator

This block turns the occupancy count of a 1024-word FIFO into four active-low status flags: empty, full, half-full, and a single flag that covers both the nearly-empty and the nearly-full band. It also gives the FIFO core two qualifiers. One blocks writes while the FIFO is full. The other blocks reads while it is empty. The FIFO core supplies the registered count, and the flags follow that count one clock edge later.

Internally the count is sorted into one of six occupancy bands, held in a state register. On every clock edge the band register takes a new value from the current count, so a jump from any band to any other band completes in a single cycle. The named transitions are:

- RECLASSIFY: the normal transition, taken on every edge outside reset. The next band is computed directly from the count.
- RESET_TO_EMPTY: taken while reset is held. The register is forced to `BAND_EMPTY`.

The six bands are:

| Band | Count range |
|---|---|
| `BAND_EMPTY` | 0 |
| `BAND_LOW` | 1 to 127 |
| `BAND_LOWMID` | 128 to 512 |
| `BAND_HIGHMID` | 513 to 896 |
| `BAND_HIGH` | 897 to 1023 |
| `BAND_FULL` | 1024 |

A mode input chooses single-device or expansion use. In expansion use, the combined nearly-empty/nearly-full output pin carries the expansion-out signal supplied by neighbouring logic. The half-full flag keeps working in both modes.

Top module: `occ_flag_gen`

## Requirements
- R1: `full_n` is 0 when the count sampled at the previous clock edge was 1024, and 1 otherwise.
- R2: `empty_n` is 0 when the count sampled at the previous clock edge was 0, and 1 otherwise.
- R3: `half_n` is 0 when the previous count was above 512, and 1 for counts from 0 to 512 inclusive. This holds in both modes.
- R4: With `single_dev`=1, `almost_xout` is 0 when the previous count was 127 or less, or 897 or more, and 1 for counts from 128 to 896.
- R5: While `rst_n`=0, whatever the count, the flags are `full_n`=1, `half_n`=1, `empty_n`=0, and `almost_xout`=0 (in single-device mode).
- R6: With `single_dev`=0, `almost_xout` equals `xout_in`, and the nearly-empty/nearly-full value does not appear on it.
- R7: `wr_inhibit` is 1 exactly when `full_n` is 0, and `rd_inhibit` is 1 exactly when `empty_n` is 0.
- R8: A change of the count reaches the flags only at the next rising clock edge. Before that edge, the flags still show the old band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level | input | 11 | Registered FIFO word count, from 0 to 1024 |
| single_dev | input | 1 | 1 selects single-device mode, 0 selects expansion mode |
| xout_in | input | 1 | Expansion-out signal, routed to `almost_xout` when `single_dev` is 0 |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |
| almost_xout | output | 1 | Nearly-empty/nearly-full flag (active low) or expansion out |
| wr_inhibit | output | 1 | Write block for the FIFO core |
| rd_inhibit | output | 1 | Read block for the FIFO core |

## Verification
The hardest cases to reach are the exact band edges: 127 against 128, 512 against 513, 896 against 897, and 1023 against 1024. A FIFO core would need hundreds of writes to get there. Because the bench drives the count port directly, it places the count on each edge value in turn and checks every flag one cycle later. It also checks that the flags have not yet moved in the half-cycle before the edge.

// File: rtl/occ_flag_pkg.sv
package occ_flag_pkg;

    typedef enum logic [2:0] {
        BAND_EMPTY   = 3'd0,
        BAND_LOW     = 3'd1,
        BAND_LOWMID  = 3'd2,
        BAND_HIGHMID = 3'd3,
        BAND_HIGH    = 3'd4,
        BAND_FULL    = 3'd5
    } band_e;

    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic half_n;
        logic almost_n;
        logic wr_inh;
        logic rd_inh;
    } flags_t;

endpackage

// File: rtl/occ_band_classify.sv
module occ_band_classify
    import occ_flag_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] level,
    output band_e         band
);
    localparam int LOW_TOP   = DEPTH / 8 - 1;
    localparam int HALF      = DEPTH / 2;
    localparam int HIGH_BASE = DEPTH - DEPTH / 8 + 1;

    localparam logic [CW-1:0] LOW_TOP_C   = CW'(LOW_TOP);
    localparam logic [CW-1:0] HALF_C      = CW'(HALF);
    localparam logic [CW-1:0] HIGH_BASE_C = CW'(HIGH_BASE);
    localparam logic [CW-1:0] DEPTH_C     = CW'(DEPTH);

    always_comb begin
        if (level == '0)
            band = BAND_EMPTY;
        else if (level <= LOW_TOP_C)
            band = BAND_LOW;
        else if (level <= HALF_C)
            band = BAND_LOWMID;
        else if (level < HIGH_BASE_C)
            band = BAND_HIGHMID;
        else if (level < DEPTH_C)
            band = BAND_HIGH;
        else
            band = BAND_FULL;
    end
endmodule

// File: rtl/occ_flag_decode.sv
module occ_flag_decode
    import occ_flag_pkg::*;
(
    input  band_e  band,
    output flags_t flags
);
    always_comb begin
        flags = '{full_n: 1'b1, empty_n: 1'b1, half_n: 1'b1,
                  almost_n: 1'b1, wr_inh: 1'b0, rd_inh: 1'b0};
        unique case (band)
            BAND_EMPTY: begin
                flags.empty_n  = 1'b0;
                flags.almost_n = 1'b0;
                flags.rd_inh   = 1'b1;
            end
            BAND_LOW: begin
                flags.almost_n = 1'b0;
            end
            BAND_LOWMID: begin
            end
            BAND_HIGHMID: begin
                flags.half_n = 1'b0;
            end
            BAND_HIGH: begin
                flags.half_n   = 1'b0;
                flags.almost_n = 1'b0;
            end
            BAND_FULL: begin
                flags.full_n   = 1'b0;
                flags.half_n   = 1'b0;
                flags.almost_n = 1'b0;
                flags.wr_inh   = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/occ_flag_gen.sv
module occ_flag_gen
    import occ_flag_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic          single_dev,
    input  logic          xout_in,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_n,
    output logic          almost_xout,
    output logic          wr_inhibit,
    output logic          rd_inhibit
);
    band_e  band_q;
    band_e  band_d;
    flags_t flg;

    occ_band_classify #(.DEPTH(DEPTH)) u_classify (
        .level (level),
        .band  (band_d)
    );

    // State register: RESET_TO_EMPTY while reset is held, RECLASSIFY on every other edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            band_q <= BAND_EMPTY;
        else
            band_q <= band_d;
    end

    occ_flag_decode u_decode (
        .band  (band_q),
        .flags (flg)
    );

    // Output process.
    always_comb begin
        full_n      = flg.full_n;
        empty_n     = flg.empty_n;
        half_n      = flg.half_n;
        almost_xout = single_dev ? flg.almost_n : xout_in;
        wr_inhibit  = flg.wr_inh;
        rd_inhibit  = flg.rd_inh;
    end

    // Checks.
    logic past_valid;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            past_valid <= 1'b0;
        else
            past_valid <= 1'b1;
    end

    // R1
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (full_n == ($past(level) != CW'(DEPTH))));

    // R2
    empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (empty_n == ($past(level) != '0)));

    // R3
    half_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid |-> (half_n == ($past(level) <= CW'(DEPTH / 2))));

    // R4
    almost_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && single_dev) |->
        (almost_xout == ($past(level) > CW'(DEPTH / 8 - 1) &&
                         $past(level) < CW'(DEPTH - DEPTH / 8 + 1))));

    // R6
    xout_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !single_dev |-> (almost_xout == xout_in));

    // R7
    inhibit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit == !full_n) && (rd_inhibit == !empty_n));
endmodule

// File: tb/occ_flag_gen_tb.sv
module occ_flag_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1024;
    localparam int CW = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] level = '0;
    logic          single_dev = 1'b1;
    logic          xout_in = 1'b0;
    logic full_n, empty_n, half_n, almost_xout, wr_inhibit, rd_inhibit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    occ_flag_gen #(.DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level),
        .single_dev  (single_dev),
        .xout_in     (xout_in),
        .full_n      (full_n),
        .empty_n     (empty_n),
        .half_n      (half_n),
        .almost_xout (almost_xout),
        .wr_inhibit  (wr_inhibit),
        .rd_inhibit  (rd_inhibit)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Expected flags, computed from the requirement thresholds.
    task automatic chk_all(input int v, input string tag);
        chk({"R1 ", tag}, "full_n", full_n, v != 1024);
        chk({"R2 ", tag}, "empty_n", empty_n, v != 0);
        chk({"R3 ", tag}, "half_n", half_n, !(v > 512));
        if (single_dev)
            chk({"R4 ", tag}, "almost_xout", almost_xout, !(v <= 127 || v >= 897));
        chk({"R7 ", tag}, "wr_inhibit", wr_inhibit, v == 1024);
        chk({"R7 ", tag}, "rd_inhibit", rd_inhibit, v == 0);
    endtask

    task automatic apply(input int v);
        @(negedge clk);
        level = CW'(v);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        single_dev = 1'b1;
        level = CW'(1024);
        repeat (2) @(negedge clk);
        chk("R5", "full_n", full_n, 1'b1);
        chk("R5", "half_n", half_n, 1'b1);
        chk("R5", "empty_n", empty_n, 1'b0);
        chk("R5", "almost_xout", almost_xout, 1'b0);
        level = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sweep_single;
        int pts[10] = '{0, 1, 127, 128, 512, 513, 896, 897, 1023, 1024};
        single_dev = 1'b1;
        foreach (pts[i]) begin
            apply(pts[i]);
            chk_all(pts[i], $sformatf("level=%0d", pts[i]));
        end
    endtask

    task automatic t_latency;
        apply(0);
        @(negedge clk);
        level = CW'(1024);
        #1;
        // R8: before the edge, the flags still show the empty band.
        chk("R8", "empty_n held", empty_n, 1'b0);
        chk("R8", "full_n held", full_n, 1'b1);
        @(negedge clk);
        chk("R8", "full_n after edge", full_n, 1'b0);
        level = CW'(600);
        #1;
        chk("R8", "half_n held", half_n, 1'b0);
        chk("R8", "full_n held", full_n, 1'b0);
        @(negedge clk);
        chk_all(600, "R8 after edge");
    endtask

    task automatic t_expansion;
        int pts[4] = '{0, 300, 700, 1024};
        single_dev = 1'b0;
        foreach (pts[i]) begin
            xout_in = 1'b1;
            apply(pts[i]);
            chk("R6", $sformatf("xout high level=%0d", pts[i]), almost_xout, 1'b1);
            xout_in = 1'b0;
            #1;
            chk("R6", $sformatf("xout low level=%0d", pts[i]), almost_xout, 1'b0);
            chk_all(pts[i], "R3 R6 expansion");
        end
        single_dev = 1'b1;
    endtask

    initial begin
        t_reset();
        t_sweep_single();
        t_latency();
        t_expansion();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule